// File: doc/BRIEF.md
# Load-Linked Word Execution Unit

This unit carries out one instruction of a small 32-bit core: a load-linked word taken from the compressed instruction set. It accepts an instruction word through an issue handshake and decodes it. It reads the base register through a register-file read port and adds a signed 9-bit displacement to form the effective address. If that address is not word aligned, the unit raises an address-error pulse and does nothing else. Otherwise it sends a doubleword read to memory, takes the 32-bit word for the current endianness out of the returned 64 bits, sign-extends it and writes it to the destination register.

A successful load also sets a single reservation. The reservation is a flag plus the linked address, and both are exposed for a later store-conditional unit. A new link always overwrites the old one. A reservation that software leaves unused needs no handling. A clear input lets the core drop the reservation, for example on exception return or on a snoop hit. Address translation is identity.

Top module: `llw_unit`

## Requirements
- R1: The instruction is recognised only when bits 31:26 equal 011000, bits 15:12 equal 0110 and bits 11:9 equal 110. Any other accepted word pulses `not_handled` for one cycle, in the cycle after acceptance. It issues no memory request, makes no register write and leaves the link flag unchanged.
- R2: The effective address is the base register value plus the sign-extended offset held in bits 8:0. The base index is in bits 20:16. Base index 0 contributes zero, whatever `rf_rdata` holds.
- R3: When effective-address bits 1:0 are nonzero, `exc_addr_err` pulses for one cycle, in the cycle after acceptance. There is no memory request, no register write and no change to the link flag.
- R4: The memory request address equals the effective address with bit 2 XORed with `reverse_endian`. Bits 1:0 and the upper bits pass through unchanged. Both endian inputs are sampled at acceptance.
- R5: The loaded word is `mem_rsp_data[63:32]` when effective-address bit 2 XOR `big_endian` is 1, and `mem_rsp_data[31:0]` otherwise. It is sign-extended to the register width.
- R6: The register write occurs in the cycle after the memory response, to the index in bits 25:21. When that index is 0, no write is made.
- R7: After a successful load's write-back cycle, `link_flag` is 1 and `link_addr` holds that load's effective address. This replaces any earlier reservation.
- R8: `clear_link` clears the link flag at the next edge. If it coincides with a write-back cycle, the new link wins.
- R9: `busy` is high and `issue_ready` low from acceptance until the write-back cycle ends. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold steady.
- R10: After reset the unit is idle: `link_flag` is 0, `busy` is 0 and no request, write, exception or not-handled pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, accepts an instruction |
| issue_instr | input | 32 | Instruction word |
| big_endian | input | 1 | CPU big-endian setting |
| reverse_endian | input | 1 | Reverse-endian control for the memory address |
| rf_raddr | output | 5 | Base register index |
| rf_rdata | input | XLEN | Base register value |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | XLEN | Sign-extended loaded word |
| mem_req_valid | output | 1 | Doubleword read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | XLEN | Request address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned doubleword |
| clear_link | input | 1 | Drop the reservation |
| exc_addr_err | output | 1 | Misaligned-address exception pulse |
| not_handled | output | 1 | Instruction word not recognised |
| busy | output | 1 | Operation in progress |
| link_flag | output | 1 | Reservation active |
| link_addr | output | XLEN | Address of the reservation |

## Verification
The assertions check several rules on every cycle. A stalled request must stay stable. Request addresses must be word aligned. Exception and not-handled pulses must not be accompanied by memory or register activity. No two result pulses may occur together. A clear outside write-back must drop the flag, and a write-back must leave the flag set. Only the bench scenarios can show the values themselves: the effective address arithmetic with negative and extreme offsets, the base-zero rule, the lane chosen under all four endian combinations, the sign-extended data, the suppressed write to register 0, and the linked address being replaced by a later link.

// File: rtl/llw_pkg.sv
package llw_pkg;
    localparam logic [5:0] OP_MAJOR = 6'b011000;
    localparam logic [3:0] OP_SUB   = 4'b0110;
    localparam logic [2:0] OP_FUNC  = 3'b110;
    localparam int         OFF_W    = 9;
    localparam int         RIDX_W   = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } llw_state_e;
endpackage

// File: rtl/llw_decode.sv
module llw_decode
    import llw_pkg::*;
(
    input  logic [31:0]       instr,
    output logic              match,
    output logic [RIDX_W-1:0] rt_idx,
    output logic [RIDX_W-1:0] base_idx,
    output logic [OFF_W-1:0]  offset
);
    always_comb begin
        match    = (instr[31:26] == OP_MAJOR) && (instr[15:12] == OP_SUB)
                && (instr[11:9] == OP_FUNC);
        rt_idx   = instr[25:21];
        base_idx = instr[20:16];
        offset   = instr[8:0];
    end
endmodule

// File: rtl/llw_agen.sv
module llw_agen
    import llw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  base_val,
    input  logic [OFF_W-1:0] offset,
    input  logic             reverse_endian,
    output logic [XLEN-1:0]  eff_addr,
    output logic [XLEN-1:0]  dw_addr,
    output logic             misaligned
);
    logic [XLEN-1:0] off_ext;

    always_comb begin
        off_ext    = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
        eff_addr   = base_val + off_ext;
        misaligned = |eff_addr[1:0];
        dw_addr    = {eff_addr[XLEN-1:3], eff_addr[2] ^ reverse_endian, eff_addr[1:0]};
    end
endmodule

// File: rtl/llw_lane.sv
module llw_lane #(
    parameter int XLEN = 32
) (
    input  logic [63:0]     dw_data,
    input  logic [2:0]      addr_lo,
    input  logic            big_endian,
    output logic [XLEN-1:0] result
);
    logic [31:0] word;

    always_comb begin
        word = (addr_lo[2] ^ big_endian) ? dw_data[63:32] : dw_data[31:0];
    end

    generate
        if (XLEN > 32) begin : g_wide
            always_comb result = {{(XLEN-32){word[31]}}, word};
        end else begin : g_narrow
            always_comb result = word;
        end
    endgenerate
endmodule

// File: rtl/llw_unit.sv
module llw_unit
    import llw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [31:0]       issue_instr,
    input  logic              big_endian,
    input  logic              reverse_endian,
    output logic [RIDX_W-1:0] rf_raddr,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              clear_link,
    output logic              exc_addr_err,
    output logic              not_handled,
    output logic              busy,
    output logic              link_flag,
    output logic [XLEN-1:0]   link_addr
);
    typedef struct packed {
        llw_state_e        st;
        logic [RIDX_W-1:0] rt;
        logic [XLEN-1:0]   ea;
        logic [XLEN-1:0]   maddr;
        logic              be;
        logic [XLEN-1:0]   wdata;
        logic              link;
        logic [XLEN-1:0]   laddr;
        logic              exc;
        logic              nh;
    } llw_regs_t;

    llw_regs_t r_q, r_d;

    logic              dec_match;
    logic [RIDX_W-1:0] dec_rt, dec_base;
    logic [OFF_W-1:0]  dec_off;
    logic [XLEN-1:0]   base_val, ag_ea, ag_dw;
    logic              ag_misal;
    logic [XLEN-1:0]   lane_val;
    logic              accept;

    llw_decode u_decode (
        .instr    (issue_instr),
        .match    (dec_match),
        .rt_idx   (dec_rt),
        .base_idx (dec_base),
        .offset   (dec_off)
    );

    always_comb base_val = (dec_base == '0) ? '0 : rf_rdata;

    llw_agen #(.XLEN(XLEN)) u_agen (
        .base_val       (base_val),
        .offset         (dec_off),
        .reverse_endian (reverse_endian),
        .eff_addr       (ag_ea),
        .dw_addr        (ag_dw),
        .misaligned     (ag_misal)
    );

    llw_lane #(.XLEN(XLEN)) u_lane (
        .dw_data    (mem_rsp_data),
        .addr_lo    (r_q.ea[2:0]),
        .big_endian (r_q.be),
        .result     (lane_val)
    );

    always_comb begin
        r_d     = r_q;
        r_d.exc = 1'b0;
        r_d.nh  = 1'b0;
        accept  = issue_valid && (r_q.st == ST_IDLE);
        if (clear_link) r_d.link = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (!dec_match) begin
                        r_d.nh = 1'b1;
                    end else if (ag_misal) begin
                        r_d.exc = 1'b1;
                    end else begin
                        r_d.st    = ST_REQ;
                        r_d.rt    = dec_rt;
                        r_d.ea    = ag_ea;
                        r_d.maddr = ag_dw;
                        r_d.be    = big_endian;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.st    = ST_WB;
                    r_d.wdata = lane_val;
                end
            end
            ST_WB: begin
                r_d.st    = ST_IDLE;
                r_d.link  = 1'b1;
                r_d.laddr = r_q.ea;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        issue_ready   = (r_q.st == ST_IDLE);
        busy          = (r_q.st != ST_IDLE);
        rf_raddr      = dec_base;
        rf_we         = (r_q.st == ST_WB) && (r_q.rt != '0);
        rf_waddr      = r_q.rt;
        rf_wdata      = r_q.wdata;
        mem_req_valid = (r_q.st == ST_REQ);
        mem_req_addr  = r_q.maddr;
        exc_addr_err  = r_q.exc;
        not_handled   = r_q.nh;
        link_flag     = r_q.link;
        link_addr     = r_q.laddr;
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    assert_exc_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_addr_err |-> !rf_we && !mem_req_valid && !busy);

    assert_exc_keeps_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_addr_err && !$past(clear_link) |-> $stable(link_flag));

    assert_nh_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        not_handled |-> !rf_we && !mem_req_valid && !busy);

    assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_addr_err, not_handled, rf_we, mem_req_valid}));

    assert_wb_links_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> link_flag && !busy);

    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_link && (r_q.st != ST_WB) |=> !link_flag);
endmodule

// File: tb/llw_unit_bench.sv
module llw_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] issue_instr = '0;
    logic        big_endian = 1'b0;
    logic        reverse_endian = 1'b0;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        clear_link = 1'b0;
    logic        exc_addr_err, not_handled, busy, link_flag;
    logic [31:0] link_addr;

    logic [31:0] regs [32];
    int          n_checks = 0;
    int          n_fail = 0;
    logic        exp_link = 1'b0;
    logic [31:0] exp_laddr = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];

    llw_unit u_llw_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_instr(issue_instr), .big_endian(big_endian), .reverse_endian(reverse_endian),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .clear_link(clear_link), .exc_addr_err(exc_addr_err), .not_handled(not_handled),
        .busy(busy), .link_flag(link_flag), .link_addr(link_addr)
    );

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [4:0] base,
                                       input logic [8:0] off);
        return {6'b011000, rt, base, 4'b0110, 3'b110, off};
    endfunction

    function automatic logic [31:0] exp_word(input logic [63:0] d, input logic [31:0] ea,
                                             input logic be);
        return (ea[2] ^ be) ? d[63:32] : d[31:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] instr, input logic be, input logic rev,
                          input bit clr_wb);
        logic [4:0]  rt, bidx;
        logic [31:0] basev, ea, eaddr, word;
        logic [63:0] data;
        bit          ok_dec;
        int          d;
        rt     = instr[25:21];
        bidx   = instr[20:16];
        basev  = (bidx == 5'd0) ? 32'd0 : regs[bidx];
        ea     = basev + {{23{instr[8]}}, instr[8:0]};
        ok_dec = (instr[31:26] == 6'b011000) && (instr[15:12] == 4'b0110)
              && (instr[11:9] == 3'b110);
        @(negedge clk);
        chk(issue_ready == 1'b1, "R9 ready idle", issue_ready, 1);
        big_endian = be; reverse_endian = rev;
        issue_valid = 1'b1; issue_instr = instr;
        @(negedge clk);
        issue_valid = 1'b0;
        if (!ok_dec) begin
            chk(not_handled && !mem_req_valid && !rf_we && !busy, "R1 not handled",
                {not_handled, mem_req_valid, rf_we, busy}, 4'b1000);
            chk(link_flag == exp_link, "R1 link kept", link_flag, exp_link);
            @(negedge clk);
            chk(!not_handled, "R1 pulse width", not_handled, 0);
            return;
        end
        if (ea[1:0] != 2'b00) begin
            chk(exc_addr_err && !mem_req_valid && !rf_we && !busy, "R3 misaligned",
                {exc_addr_err, mem_req_valid, rf_we, busy}, 4'b1000);
            chk(link_flag == exp_link, "R3 link kept", link_flag, exp_link);
            @(negedge clk);
            chk(!exc_addr_err, "R3 pulse width", exc_addr_err, 0);
            return;
        end
        eaddr = {ea[31:3], ea[2] ^ rev, ea[1:0]};
        chk(busy && !issue_ready && mem_req_valid, "R9 busy on issue",
            {busy, issue_ready, mem_req_valid}, 3'b101);
        chk(mem_req_addr == eaddr, "R2 R4 request address", mem_req_addr, eaddr);
        d = $urandom % 3;
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == eaddr, "R9 request held", mem_req_addr, eaddr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid && busy, "R9 waiting", {mem_req_valid, busy}, 2'b01);
        d = $urandom % 3;
        for (int i = 0; i < d; i++) @(negedge clk);
        data = {$urandom, $urandom};
        if ($urandom % 2) data[63] = 1'b1;
        word = exp_word(data, ea, be);
        mem_rsp_valid = 1'b1; mem_rsp_data = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        chk(rf_we == (rt != 5'd0), "R6 write strobe", rf_we, rt != 5'd0);
        if (rt != 5'd0) begin
            chk(rf_waddr == rt, "R6 write index", rf_waddr, rt);
            chk(rf_wdata == word, "R5 loaded word", rf_wdata, word);
        end
        chk(busy, "R9 busy in write-back", busy, 1);
        if (clr_wb) clear_link = 1'b1;
        @(negedge clk);
        clear_link = 1'b0;
        chk(link_flag == 1'b1, clr_wb ? "R8 set wins" : "R7 link set", link_flag, 1);
        chk(link_addr == ea, "R7 link address", link_addr, ea);
        chk(!busy && !rf_we, "R9 idle after", {busy, rf_we}, 0);
        if (rt != 5'd0) regs[rt] = word;
        exp_link = 1'b1; exp_laddr = ea;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < 32; i++) regs[i] = {$urandom, 2'b00} ^ 32'h1000_0000;
        regs[0] = 32'h0BAD_F000;
        repeat (3) @(negedge clk);
        chk(!busy && !link_flag && !mem_req_valid && !rf_we && !exc_addr_err && !not_handled,
            "R10 reset state", {busy, link_flag, mem_req_valid, rf_we, exc_addr_err, not_handled}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_ready && !link_flag, "R10 idle after reset", {issue_ready, link_flag}, 2'b10);

        run_op(mk(5'd3, 5'd4, 9'd8), 1'b0, 1'b0, 0);
        run_op(mk(5'd5, 5'd4, 9'h100), 1'b0, 1'b1, 0);
        run_op(mk(5'd6, 5'd7, 9'd252), 1'b1, 1'b0, 0);
        run_op(mk(5'd8, 5'd7, 9'd4), 1'b1, 1'b1, 0);
        run_op(mk(5'd9, 5'd0, 9'd20), 1'b0, 1'b0, 0);
        run_op(mk(5'd0, 5'd10, 9'd12), 1'b1, 1'b0, 0);
        run_op(mk(5'd11, 5'd12, 9'd1), 1'b0, 1'b0, 0);
        run_op(mk(5'd11, 5'd12, 9'd2), 1'b0, 1'b0, 0);
        run_op(mk(5'd11, 5'd12, 9'h1FF), 1'b0, 1'b0, 0);
        run_op(mk(5'd13, 5'd14, 9'd16) ^ 32'h0400_0000, 1'b0, 1'b0, 0);
        run_op(mk(5'd13, 5'd14, 9'd16) ^ 32'h0000_1000, 1'b0, 1'b0, 0);
        run_op(mk(5'd13, 5'd14, 9'd16) ^ 32'h0000_0200, 1'b0, 1'b0, 0);

        @(negedge clk);
        clear_link = 1'b1;
        @(negedge clk);
        clear_link = 1'b0;
        exp_link = 1'b0;
        chk(!link_flag, "R8 clear", link_flag, 0);
        run_op(mk(5'd15, 5'd16, 9'd28), 1'b1, 1'b0, 1);

        for (int k = 0; k < 40; k++) begin
            logic [31:0] ins;
            logic [8:0]  off;
            int          sel;
            off = ($urandom % 4 == 0) ? 9'($urandom) : {7'($urandom), 2'b00};
            ins = mk(5'($urandom), 5'($urandom), off);
            sel = $urandom % 8;
            if (sel == 0) ins[31:26] = 6'($urandom);
            if (sel == 1) ins[11:9] = 3'($urandom);
            run_op(ins, 1'($urandom), 1'($urandom), ($urandom % 5) == 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule